// File: doc/BRIEF.md
# Bridge Data Parity and System Error Reporter

This block is the error-reporting logic of a two-sided bus bridge with a primary and a secondary interface. During each data phase it checks the parity that the initiator drives on its bus. It then raises that side's active-low parity-error output, marks the forwarded copy of bad data so the far bus carries bad parity too, and records sticky status. It also turns a parity error reported by the target of a posted write into a primary-side system-error pulse. That pulse is qualified by enable bits that differ by direction.

A transaction is opened with a one-cycle start strobe. Direction and kind are held for the whole transaction. The kind is posted write, read, or a data phase that carries a parity error passed back from the target bus. The bridge's buffering logic asks for the invert flag when it drives each forwarded data phase on the opposite bus. Status bits stay set until software writes a one to the matching clear bit.

Top module: `bridge_err_report`

## Requirements
- R1: Parity is even over AD and C/BE together, and PAR arrives one clock after the data it covers. A mismatch in an initiator-side data phase drives that side's perr_n low for one clock, two clocks after the data phase, when that side's enable is set. Primary uses pri_per_en and secondary uses sec_per_en. Downstream (xact_dir=0) the initiator is the primary side; upstream (xact_dir=1) it is the secondary side.
- R2: When that side's enable is clear, a mismatch leaves perr_n high.
- R3: A mismatch sets the side's parity-error status bit whatever the enables are, visible two clocks after the data phase. err_stat bit 0 is primary and bit 1 is secondary.
- R4: Every posted-write initiator data phase queues one mark in order. When the opposite bus flags an outgoing data phase (sec_out_dvld downstream, pri_out_dvld upstream), that bus's inv_par output is high in the same cycle exactly when the oldest queued mark was bad. With nothing queued it stays low.
- R5: In a passed-back kind (xact_kind=2) data phase with correct parity, the initiator side's perr_n goes low two clocks later only when both enables are set and no error has been forwarded in the transaction. The parity-error status bit is not set.
- R6: A secondary target report (sec_tgt_perr) during a downstream posted write (xact_kind=0) sets err_stat bit 3 on the next clock when sec_per_en is set.
- R7: A primary target report (pri_tgt_perr) during an upstream posted write sets err_stat bit 2 on the next clock when pri_per_en is set.
- R8: After a downstream report, pri_serr_n is low for one clock on the next cycle and err_stat bit 4 sets, only if serr_en and both enables are set, pwr_serr_dis is clear, and no error was forwarded in the transaction.
- R9: After an upstream report, the same system error follows, with pwr_serr_dis having no effect.
- R10: An error forwarded from the initiator bus blocks the system error until the next xact_start, which clears the record.
- R11: Status bits are sticky. A one in err_stat_clr clears the matching bit, and a set in the same cycle wins.
- R12: Reset clears all status and the mark queues and leaves perr_n and serr_n high and inv_par low.
- R13: Read-kind data phases are not checked. Target reports from the initiator side of the transaction are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pri_per_en | input | 1 | Primary parity response enable |
| sec_per_en | input | 1 | Secondary parity response enable |
| serr_en | input | 1 | System error enable |
| pwr_serr_dis | input | 1 | Disables system error for downstream posted-write reports |
| xact_start | input | 1 | First cycle of a transaction; clears the forwarded-error record |
| xact_dir | input | 1 | 0 downstream, 1 upstream |
| xact_kind | input | 2 | 0 posted write, 1 read, 2 passed-back error, 3 treated as read |
| pri_dvld | input | 1 | Primary data phase this cycle |
| pri_ad | input | AD_W | Primary address/data |
| pri_cbe | input | BE_W | Primary command/byte enables |
| pri_par | input | 1 | Primary parity, one clock after data |
| sec_dvld | input | 1 | Secondary data phase this cycle |
| sec_ad | input | AD_W | Secondary address/data |
| sec_cbe | input | BE_W | Secondary command/byte enables |
| sec_par | input | 1 | Secondary parity, one clock after data |
| pri_tgt_perr | input | 1 | Primary target reported a parity error |
| sec_tgt_perr | input | 1 | Secondary target reported a parity error |
| pri_out_dvld | input | 1 | Bridge drives a forwarded data phase on primary |
| sec_out_dvld | input | 1 | Bridge drives a forwarded data phase on secondary |
| err_stat_clr | input | 5 | Write-one-to-clear pulses per status bit |
| pri_perr_n | output | 1 | Primary parity error, active low |
| sec_perr_n | output | 1 | Secondary parity error, active low |
| pri_serr_n | output | 1 | Primary system error, active low |
| pri_inv_par | output | 1 | Invert parity on the current primary forwarded phase |
| sec_inv_par | output | 1 | Invert parity on the current secondary forwarded phase |
| err_stat | output | 5 | Sticky status: 0 pri parity, 1 sec parity, 2 pri target report, 3 sec target report, 4 system error signaled |

## Verification
A stale compare stage shows up as a perr_n pulse in the wrong cycle, or on the wrong side, two clocks after the data phase. A misordered or miscounted mark queue shows as an inv_par value that does not match the bad phase, at the first forwarded phase on the far bus. A forwarded-error record that is not cleared or not set shows on the next target report, either as a missing pri_serr_n pulse or as an extra one one clock later, with status bit 4 matching it. Sticky-status faults show at err_stat one clock after a set or a clear pulse.

// File: rtl/bre_pkg.sv
package bre_pkg;
   typedef enum logic [1:0] {
      XK_PWR      = 2'b00,
      XK_READ     = 2'b01,
      XK_PASSBACK = 2'b10,
      XK_RSVD     = 2'b11
   } xact_kind_e;

   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } xact_dir_e;

   localparam int ST_PRI_PE  = 0;
   localparam int ST_SEC_PE  = 1;
   localparam int ST_PRI_DPD = 2;
   localparam int ST_SEC_DPD = 3;
   localparam int ST_SSE     = 4;
   localparam int ST_W       = 5;

   typedef struct packed {
      logic vld;
      logic exp_par;
      logic pwr;
      logic pb;
   } chk_stage_t;
endpackage

// File: rtl/bre_par_check.sv
module bre_par_check
   import bre_pkg::*;
#(
   parameter int AD_W = 32,
   parameter int BE_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [1:0]      kind,
   input  logic [AD_W-1:0] ad,
   input  logic [BE_W-1:0] cbe,
   input  logic            par,
   output logic            chk_vld,
   output logic            chk_bad,
   output logic            chk_pwr,
   output logic            chk_pb
);
   chk_stage_t st_q;
   logic       is_pwr, is_pb;

   assign is_pwr = (kind == XK_PWR);
   assign is_pb  = (kind == XK_PASSBACK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= '0;
      end else begin
         st_q.vld     <= en & (is_pwr | is_pb);
         st_q.exp_par <= ^{ad, cbe};
         st_q.pwr     <= en & is_pwr;
         st_q.pb      <= en & is_pb;
      end
   end

   assign chk_vld = st_q.vld;
   assign chk_bad = st_q.vld & (par ^ st_q.exp_par);
   assign chk_pwr = st_q.pwr;
   assign chk_pb  = st_q.pb;

   // R1
   bad_follows_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_bad |-> $past(en));
endmodule

// File: rtl/bre_mark_fifo.sv
module bre_mark_fifo #(
   parameter int DEPTH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic push,
   input  logic push_bit,
   input  logic pop,
   output logic head_bit,
   output logic empty
);
   generate
      if (DEPTH == 1) begin : g_single
         logic vld_q, bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               bit_q <= 1'b0;
            end else if (push) begin
               vld_q <= 1'b1;
               bit_q <= push_bit;
            end else if (pop) begin
               vld_q <= 1'b0;
            end
         end
         assign head_bit = bit_q;
         assign empty    = ~vld_q;

         // R4
         no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            push |-> (!vld_q || pop));
      end else begin : g_ring
         localparam int AW = $clog2(DEPTH);
         localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
         logic [DEPTH-1:0] mem_q;
         logic [AW-1:0]    wr_q, rd_q;
         logic [AW:0]      cnt_q;
         logic             do_push, do_pop;

         assign do_pop  = pop & (cnt_q != '0);
         assign do_push = push & ((cnt_q != FULL_CNT) | do_pop);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mem_q <= '0;
               wr_q  <= '0;
               rd_q  <= '0;
               cnt_q <= '0;
            end else begin
               if (do_push) begin
                  mem_q[wr_q] <= push_bit;
                  wr_q        <= wr_q + 1'b1;
               end
               if (do_pop) rd_q <= rd_q + 1'b1;
               case ({do_push, do_pop})
                  2'b10:   cnt_q <= cnt_q + 1'b1;
                  2'b01:   cnt_q <= cnt_q - 1'b1;
                  default: cnt_q <= cnt_q;
               endcase
            end
         end
         assign head_bit = mem_q[rd_q];
         assign empty    = (cnt_q == '0);

         // R4
         no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            push |-> ((cnt_q != FULL_CNT) || pop));
      end
   endgenerate
endmodule

// File: rtl/bridge_err_report.sv
module bridge_err_report
   import bre_pkg::*;
#(
   parameter int AD_W      = 32,
   parameter int BE_W      = 4,
   parameter int FWD_DEPTH = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pri_per_en,
   input  logic            sec_per_en,
   input  logic            serr_en,
   input  logic            pwr_serr_dis,
   input  logic            xact_start,
   input  logic            xact_dir,
   input  logic [1:0]      xact_kind,
   input  logic            pri_dvld,
   input  logic [AD_W-1:0] pri_ad,
   input  logic [BE_W-1:0] pri_cbe,
   input  logic            pri_par,
   input  logic            sec_dvld,
   input  logic [AD_W-1:0] sec_ad,
   input  logic [BE_W-1:0] sec_cbe,
   input  logic            sec_par,
   input  logic            pri_tgt_perr,
   input  logic            sec_tgt_perr,
   input  logic            pri_out_dvld,
   input  logic            sec_out_dvld,
   input  logic [4:0]      err_stat_clr,
   output logic            pri_perr_n,
   output logic            sec_perr_n,
   output logic            pri_serr_n,
   output logic            pri_inv_par,
   output logic            sec_inv_par,
   output logic [4:0]      err_stat
);
   localparam int NSIDE = 2;

   generate
      if (AD_W != 8 * BE_W) begin : g_bad_width
         $error("AD_W must be eight times BE_W");
      end
      if (FWD_DEPTH < 1 || (FWD_DEPTH & (FWD_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("FWD_DEPTH must be a power of two");
      end
   endgenerate

   logic            dn, both_per, is_pwr;
   logic [NSIDE-1:0] s_en, s_par, s_out, s_per;
   logic [AD_W-1:0] s_ad [NSIDE];
   logic [BE_W-1:0] s_be [NSIDE];
   logic [NSIDE-1:0] c_vld, c_bad, c_pwr, c_pb;
   logic [NSIDE-1:0] f_head, f_empty, inv, fire;
   logic [NSIDE-1:0] perr_q;
   logic            fwd_flag_q, fwd_now;
   logic            rpt_dn, rpt_up, serr_fire, serr_q;
   logic [ST_W-1:0] st_set, stat_q;

   assign dn       = (xact_dir == DIR_DOWN);
   assign both_per = pri_per_en & sec_per_en;
   assign is_pwr   = (xact_kind == XK_PWR);

   assign s_en[0]  = pri_dvld & dn;
   assign s_en[1]  = sec_dvld & ~dn;
   assign s_par    = {sec_par, pri_par};
   assign s_out    = {sec_out_dvld, pri_out_dvld};
   assign s_per    = {sec_per_en, pri_per_en};
   assign s_ad[0]  = pri_ad;
   assign s_ad[1]  = sec_ad;
   assign s_be[0]  = pri_cbe;
   assign s_be[1]  = sec_cbe;

   generate
      for (genvar g = 0; g < NSIDE; g++) begin : g_side
         localparam int OPP = NSIDE - 1 - g;

         bre_par_check #(.AD_W(AD_W), .BE_W(BE_W)) u_chk (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (s_en[g]),
            .kind    (xact_kind),
            .ad      (s_ad[g]),
            .cbe     (s_be[g]),
            .par     (s_par[g]),
            .chk_vld (c_vld[g]),
            .chk_bad (c_bad[g]),
            .chk_pwr (c_pwr[g]),
            .chk_pb  (c_pb[g])
         );

         bre_mark_fifo #(.DEPTH(FWD_DEPTH)) u_marks (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (c_pwr[g]),
            .push_bit (c_bad[g]),
            .pop      (s_out[OPP]),
            .head_bit (f_head[g]),
            .empty    (f_empty[g])
         );

         assign inv[OPP]  = s_out[OPP] & ~f_empty[g] & f_head[g];
         assign fire[g]   = c_vld[g] &
                            (c_bad[g] ? s_per[g] : (c_pb[g] & both_per & ~fwd_flag_q));

         // R1
         perr_two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            perr_q[g] |-> $past(s_en[g], 2));
      end
   endgenerate

   assign fwd_now = |(c_pwr & c_bad);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          fwd_flag_q <= 1'b0;
      else if (xact_start) fwd_flag_q <= 1'b0;
      else if (fwd_now)    fwd_flag_q <= 1'b1;
   end

   assign rpt_dn    = sec_tgt_perr & dn & is_pwr;
   assign rpt_up    = pri_tgt_perr & ~dn & is_pwr;
   assign serr_fire = serr_en & both_per & ~(fwd_flag_q | fwd_now) &
                      ((rpt_dn & ~pwr_serr_dis) | rpt_up);

   always_comb begin
      st_set             = '0;
      st_set[ST_PRI_PE]  = c_bad[0];
      st_set[ST_SEC_PE]  = c_bad[1];
      st_set[ST_PRI_DPD] = rpt_up & pri_per_en;
      st_set[ST_SEC_DPD] = rpt_dn & sec_per_en;
      st_set[ST_SSE]     = serr_fire;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         perr_q <= '0;
         serr_q <= 1'b0;
         stat_q <= '0;
      end else begin
         perr_q <= fire;
         serr_q <= serr_fire;
         stat_q <= (stat_q & ~err_stat_clr) | st_set;
      end
   end

   assign pri_perr_n  = ~perr_q[0];
   assign sec_perr_n  = ~perr_q[1];
   assign pri_serr_n  = ~serr_q;
   assign pri_inv_par = inv[0];
   assign sec_inv_par = inv[1];
   assign err_stat    = stat_q;

   // R8
   serr_needs_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
      serr_q |-> $past(serr_en && pri_per_en && sec_per_en));
   // R8
   serr_dn_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (serr_q && $past(xact_dir == DIR_DOWN)) |-> !$past(pwr_serr_dis));
   // R10
   serr_after_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      serr_q |-> !$past(fwd_flag_q));
   // R11
   stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(stat_q) & ~$past(err_stat_clr)) & ~stat_q) == '0));
endmodule

// File: tb/test_bridge_err_report.sv
module test_bridge_err_report;
   localparam int AD_W = 32;
   localparam int BE_W = 4;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, pri_per_en, sec_per_en, serr_en, pwr_serr_dis;
   logic xact_start, xact_dir;
   logic [1:0] xact_kind;
   logic pri_dvld, pri_par, sec_dvld, sec_par;
   logic [AD_W-1:0] pri_ad, sec_ad;
   logic [BE_W-1:0] pri_cbe, sec_cbe;
   logic pri_tgt_perr, sec_tgt_perr, pri_out_dvld, sec_out_dvld;
   logic [4:0] err_stat_clr, err_stat;
   logic pri_perr_n, sec_perr_n, pri_serr_n, pri_inv_par, sec_inv_par;
   logic pri_bad, sec_bad;

   bridge_err_report #(.AD_W(AD_W), .BE_W(BE_W), .FWD_DEPTH(8)) i_bridge_err_report (
      .clk(clk), .rst_n(rst_n), .pri_per_en(pri_per_en), .sec_per_en(sec_per_en),
      .serr_en(serr_en), .pwr_serr_dis(pwr_serr_dis), .xact_start(xact_start),
      .xact_dir(xact_dir), .xact_kind(xact_kind),
      .pri_dvld(pri_dvld), .pri_ad(pri_ad), .pri_cbe(pri_cbe), .pri_par(pri_par),
      .sec_dvld(sec_dvld), .sec_ad(sec_ad), .sec_cbe(sec_cbe), .sec_par(sec_par),
      .pri_tgt_perr(pri_tgt_perr), .sec_tgt_perr(sec_tgt_perr),
      .pri_out_dvld(pri_out_dvld), .sec_out_dvld(sec_out_dvld),
      .err_stat_clr(err_stat_clr), .pri_perr_n(pri_perr_n), .sec_perr_n(sec_perr_n),
      .pri_serr_n(pri_serr_n), .pri_inv_par(pri_inv_par), .sec_inv_par(sec_inv_par),
      .err_stat(err_stat)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int         at;
      int         sig;
      logic [4:0] val;
      string      req;
   } exp_t;
   exp_t sbq[$];
   int   n_vec = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   task automatic expect_at(int at, int sig, logic [4:0] val, string req);
      exp_t e;
      e.at = at; e.sig = sig; e.val = val; e.req = req;
      sbq.push_back(e);
   endtask

   function automatic logic [4:0] observe(int sig);
      case (sig)
         0:       return {4'b0, pri_perr_n};
         1:       return {4'b0, sec_perr_n};
         2:       return {4'b0, pri_serr_n};
         3:       return err_stat;
         4:       return {4'b0, pri_inv_par};
         default: return {4'b0, sec_inv_par};
      endcase
   endfunction

   function automatic string sig_name(int sig);
      case (sig)
         0:       return "pri_perr_n";
         1:       return "sec_perr_n";
         2:       return "pri_serr_n";
         3:       return "err_stat";
         4:       return "pri_inv_par";
         default: return "sec_inv_par";
      endcase
   endfunction

   // monitor: pop every item due in this cycle and compare
   always @(negedge clk) begin
      for (int i = sbq.size() - 1; i >= 0; i--) begin
         if (sbq[i].at <= cyc) begin
            n_vec++;
            if (sbq[i].at < cyc || observe(sbq[i].sig) !== sbq[i].val) begin
               n_bad++;
               $display("FAIL %s %s cycle %0d: actual %b expected %b", sbq[i].req,
                        sig_name(sbq[i].sig), cyc, observe(sbq[i].sig), sbq[i].val);
            end
            sbq.delete(i);
         end
      end
   end

   task automatic tick();
      logic np, ns;
      np = pri_dvld ? ((^{pri_ad, pri_cbe}) ^ pri_bad) : 1'b0;
      ns = sec_dvld ? ((^{sec_ad, sec_cbe}) ^ sec_bad) : 1'b0;
      @(posedge clk); #1;
      pri_par = np; sec_par = ns;
      pri_dvld = 0; sec_dvld = 0; pri_bad = 0; sec_bad = 0;
      pri_tgt_perr = 0; sec_tgt_perr = 0; pri_out_dvld = 0; sec_out_dvld = 0;
      err_stat_clr = '0; xact_start = 0;
   endtask

   task automatic phase(int side, logic [31:0] ad, logic [3:0] be, logic bad);
      if (side == 0) begin
         pri_dvld = 1; pri_ad = ad; pri_cbe = be; pri_bad = bad;
      end else begin
         sec_dvld = 1; sec_ad = ad; sec_cbe = be; sec_bad = bad;
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 0; pri_per_en = 0; sec_per_en = 0; serr_en = 0; pwr_serr_dis = 0;
      xact_start = 0; xact_dir = 0; xact_kind = 2'd0;
      pri_dvld = 0; sec_dvld = 0; pri_ad = '0; sec_ad = '0; pri_cbe = '0; sec_cbe = '0;
      pri_par = 0; sec_par = 0; pri_bad = 0; sec_bad = 0;
      pri_tgt_perr = 0; sec_tgt_perr = 0; pri_out_dvld = 0; sec_out_dvld = 0;
      err_stat_clr = '0;
      tick(); tick();
      rst_n = 1;
      // R12 reset state, empty queue gives no invert flag
      sec_out_dvld = 1; pri_out_dvld = 1;
      expect_at(cyc, 0, 5'd1, "R12"); expect_at(cyc, 1, 5'd1, "R12");
      expect_at(cyc, 2, 5'd1, "R12"); expect_at(cyc, 3, 5'd0, "R12");
      expect_at(cyc, 4, 5'd0, "R12"); expect_at(cyc, 5, 5'd0, "R12");
      tick();

      // downstream posted write, middle phase bad
      pri_per_en = 1; sec_per_en = 1; serr_en = 1; pwr_serr_dis = 0;
      xact_dir = 0; xact_kind = 2'd0; xact_start = 1;
      phase(0, 32'h1234_5678, 4'hF, 0);
      expect_at(cyc + 2, 0, 5'd1, "R1"); expect_at(cyc + 2, 3, 5'd0, "R3");
      tick();
      phase(0, 32'hA5A5_0001, 4'h3, 1);
      expect_at(cyc + 2, 0, 5'd0, "R1"); expect_at(cyc + 2, 1, 5'd1, "R1");
      expect_at(cyc + 2, 3, 5'b00001, "R3");
      tick();
      phase(0, 32'h0000_00FF, 4'h1, 0);
      expect_at(cyc + 2, 0, 5'd1, "R1");
      tick(); tick(); tick();
      sec_out_dvld = 1; expect_at(cyc, 5, 5'd0, "R4"); tick();
      sec_out_dvld = 1; expect_at(cyc, 5, 5'd1, "R4"); tick();
      sec_out_dvld = 1; expect_at(cyc, 5, 5'd0, "R4"); tick();
      sec_out_dvld = 1; expect_at(cyc, 5, 5'd0, "R4"); tick();
      // R10 target report after forwarded error: no system error
      sec_tgt_perr = 1;
      expect_at(cyc + 1, 2, 5'd1, "R10"); expect_at(cyc + 1, 3, 5'b01001, "R6");
      tick();
      err_stat_clr = 5'b01001; expect_at(cyc + 1, 3, 5'b00000, "R11"); tick();

      // new transaction clears the record: system error fires
      xact_start = 1; tick();
      sec_tgt_perr = 1;
      expect_at(cyc + 1, 2, 5'd0, "R8"); expect_at(cyc + 2, 2, 5'd1, "R8");
      expect_at(cyc + 1, 3, 5'b11000, "R8");
      tick(); tick();

      // event disable blocks downstream system error
      err_stat_clr = 5'b11111; tick();
      pwr_serr_dis = 1; sec_tgt_perr = 1;
      expect_at(cyc + 1, 2, 5'd1, "R8"); expect_at(cyc + 1, 3, 5'b01000, "R8");
      tick();
      sec_tgt_perr = 1; err_stat_clr = 5'b01000;
      expect_at(cyc + 1, 3, 5'b01000, "R11");
      tick();
      sec_per_en = 0; err_stat_clr = 5'b01000; tick();
      sec_tgt_perr = 1;
      expect_at(cyc + 1, 3, 5'b00000, "R6"); expect_at(cyc + 1, 2, 5'd1, "R8");
      tick();
      sec_per_en = 1;

      // upstream report, disable bit has no effect
      xact_dir = 1; xact_start = 1; tick();
      pri_tgt_perr = 1;
      expect_at(cyc + 1, 2, 5'd0, "R9"); expect_at(cyc + 1, 3, 5'b10100, "R7");
      tick();
      err_stat_clr = 5'b11111; tick();

      // upstream posted write, secondary enable clear
      xact_start = 1; tick();
      sec_per_en = 0;
      phase(1, 32'h0F0F_0F0F, 4'hC, 1);
      expect_at(cyc + 2, 1, 5'd1, "R2"); expect_at(cyc + 2, 3, 5'b00010, "R3");
      tick(); tick(); tick();
      sec_per_en = 1; pri_tgt_perr = 1;
      expect_at(cyc + 1, 2, 5'd1, "R10"); expect_at(cyc + 1, 3, 5'b00110, "R7");
      tick();
      pri_out_dvld = 1; expect_at(cyc, 4, 5'd1, "R4"); tick();
      err_stat_clr = 5'b11111; tick();

      // passed-back error on upstream transaction
      xact_kind = 2'd2; xact_start = 1; tick();
      phase(1, 32'h0000_1111, 4'h0, 0);
      expect_at(cyc + 2, 1, 5'd0, "R5"); expect_at(cyc + 2, 3, 5'b00000, "R5");
      tick(); tick();
      pri_per_en = 0;
      phase(1, 32'h0000_2222, 4'h0, 0);
      expect_at(cyc + 2, 1, 5'd1, "R5");
      tick(); tick(); tick();
      pri_per_en = 1;

      // R13 read data phases and initiator-side reports ignored
      xact_dir = 0; xact_kind = 2'd1; xact_start = 1; tick();
      phase(0, 32'hDEAD_BEEF, 4'h5, 1);
      expect_at(cyc + 2, 0, 5'd1, "R13"); expect_at(cyc + 2, 3, 5'b00000, "R13");
      tick(); tick();
      sec_out_dvld = 1; expect_at(cyc, 5, 5'd0, "R13"); tick();
      xact_kind = 2'd0; xact_start = 1; tick();
      pri_tgt_perr = 1;
      expect_at(cyc + 1, 2, 5'd1, "R13"); expect_at(cyc + 1, 3, 5'b00000, "R13");
      tick();

      // R1 secondary side uses its own enable, C/BE counted in parity
      xact_dir = 1; xact_start = 1; pri_per_en = 0; tick();
      phase(1, 32'h0000_0003, 4'b0111, 0);
      expect_at(cyc + 2, 1, 5'd1, "R1");
      tick();
      phase(1, 32'h0000_0003, 4'b0111, 1);
      expect_at(cyc + 2, 1, 5'd0, "R1"); expect_at(cyc + 2, 3, 5'b00010, "R3");
      tick(); tick(); tick(); tick();

      done = 1'b1;
      summary();
      $finish;
   end
endmodule